// File: doc/BRIEF.md
# Light Window Interrupt Controller

This block sits behind the conversion engine of a three-channel (red, green, blue) light sensor and produces the host interrupt. Each finished conversion arrives as one transfer carrying three 16-bit channel results. A configuration byte picks which channel is watched. That channel's result is compared against a programmable low and high threshold window. A run counter requires a chosen number of back-to-back out-of-window results before the interrupt fires. When the block fires, a status flag goes high and the active-low interrupt pin goes low. Both stay that way until the host signals that its read of the status byte is complete.

An enable bit in the same configuration byte can also raise the interrupt on every finished conversion, whether or not any channel is watched. The conversion input follows valid/ready rules. A result is taken in any cycle where `conv_valid` and `conv_ready` are both high. The block never applies back-pressure, so `conv_ready` is always high and the producer may present one result per cycle. The status-read strobe, the configuration byte and the thresholds are plain level or pulse inputs.

Configuration byte layout: bits 1:0 select the watched channel, bits 3:2 set the run length, bit 4 enables the interrupt on every conversion, and bits 7:5 are reserved. A run is a sequence of consecutive out-of-window results on the watched channel. The run is restarted after each firing, on any in-window result, and whenever the channel or run-length field changes.

Top module: `light_irq_ctrl`

## Requirements
- R1: While reset is active and after its release, `irq_flag` is 0 and `irq_n` is 1.
- R2: Configuration bits 1:0 select the watched channel: 01 = green, 10 = red, 11 = blue. Results on the channels that are not selected have no effect on the window logic.
- R3: The window test is strict. A watched result strictly below `win_lo` or strictly above `win_hi` counts as out of window. A result equal to either threshold, or between them, does not.
- R4: Configuration bits 3:2 set the run length: 00 = 1, 01 = 2, 10 = 4, 11 = 8 consecutive out-of-window results. The flag rises in the cycle after the result that completes the run is accepted.
- R5: An in-window result on the watched channel restarts the run from zero. After a firing, the run also restarts from zero.
- R6: A change in configuration bits 3:0 restarts the run from zero.
- R7: When the block fires, `irq_flag` goes to 1 and `irq_n` goes to 0 together. Both hold until a cycle with `stat_rd_done` high, and both clear in the cycle after that strobe.
- R8: If a firing event and `stat_rd_done` occur in the same cycle, the flag is set or stays set.
- R9: When configuration bit 4 is 1, every accepted conversion fires the interrupt. When bit 4 is 0, conversions fire only through the window path.
- R10: With bits 1:0 at 00, the window path never fires, whatever the results are. The conversion path of R9 still works in this setting.
- R11: Configuration bits 7:5 have no effect. Changing only these bits does not restart the run.
- R12: `conv_ready` is always 1, so a result presented with `conv_valid` high is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | A finished conversion is presented |
| conv_ready | output | 1 | Block accepts a conversion (always 1) |
| red_res | input | 16 | Red channel result |
| green_res | input | 16 | Green channel result |
| blue_res | input | 16 | Blue channel result |
| win_lo | input | 16 | Low threshold of the window |
| win_hi | input | 16 | High threshold of the window |
| cfg_byte | input | 8 | Configuration byte (layout in text above) |
| stat_rd_done | input | 1 | Pulse: host finished reading the status byte |
| irq_flag | output | 1 | Interrupt status flag, active high |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
Each outcome is registered exactly once. An accepted conversion, a status-read strobe or a configuration change therefore shows on `irq_flag` and `irq_n` at the first rising edge after the cycle in which it was presented. The bench drives every input on the falling edge and holds it for one full cycle. It then reads the outputs at the next falling edge, which is half a cycle after the edge that registered the result. A behavioural reference model is updated on each rising edge from the same inputs and compared at every falling edge. Directed checks with hand-computed expected values cover each requirement's corner cases.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int RUN_W   = 4;
  localparam int MAX_RUN = 8;

  typedef enum logic [1:0] {
    CH_NONE  = 2'b00,
    CH_GREEN = 2'b01,
    CH_RED   = 2'b10,
    CH_BLUE  = 2'b11
  } chan_sel_e;

  function automatic logic [RUN_W-1:0] run_len(input logic [1:0] code);
    return RUN_W'(1) << code;
  endfunction

endpackage

// File: rtl/lirq_window.sv
module lirq_window
  import lirq_pkg::*;
#(
  parameter int DW = 16
) (
  input  chan_sel_e         chan,
  input  logic [DW-1:0]     red_res,
  input  logic [DW-1:0]     green_res,
  input  logic [DW-1:0]     blue_res,
  input  logic [DW-1:0]     win_lo,
  input  logic [DW-1:0]     win_hi,
  output logic              hit
);

  localparam int NCH = 3;

  logic [DW-1:0]  res [NCH];
  logic [NCH-1:0] outside;

  assign res[0] = green_res;
  assign res[1] = red_res;
  assign res[2] = blue_res;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign outside[g] = (res[g] < win_lo) || (res[g] > win_hi);
  end

  always_comb begin
    case (chan)
      CH_GREEN: hit = outside[0];
      CH_RED:   hit = outside[1];
      CH_BLUE:  hit = outside[2];
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/lirq_persist.sv
module lirq_persist
  import lirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_acc,
  input  logic       hit,
  input  logic [1:0] persist,
  input  logic       cfg_change,
  output logic       fire
);

  logic [RUN_W-1:0] cnt_q, cnt_d, base, nxt, need;

  assign need = run_len(persist);
  assign base = cfg_change ? '0 : cnt_q;
  assign nxt  = base + RUN_W'(1);
  assign fire = conv_acc && hit && (nxt >= need);

  always_comb begin
    cnt_d = base;
    if (conv_acc) begin
      if (hit && !fire) cnt_d = nxt;
      else              cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_run_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < RUN_W'(MAX_RUN));

  assert_inwindow_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(conv_acc && !hit) |-> cnt_q == '0);

  assert_cfg_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_change && !conv_acc) |-> cnt_q == '0);

endmodule

// File: rtl/lirq_flag.sv
module lirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic pin_n
);

  logic flag_q, pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b1;
    end else if (set) begin
      flag_q <= 1'b1;
      pin_q  <= 1'b0;
    end else if (clr) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b1;
    end
  end

  assign flag  = flag_q;
  assign pin_n = pin_q;

  assert_pin_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_n == !flag);

  assert_hold_until_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(flag && !clr) |-> flag);

  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clr && !set) |-> !flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(set) |-> flag);

endmodule

// File: rtl/light_irq_ctrl.sv
module light_irq_ctrl
  import lirq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  output logic          conv_ready,
  input  logic [DW-1:0] red_res,
  input  logic [DW-1:0] green_res,
  input  logic [DW-1:0] blue_res,
  input  logic [DW-1:0] win_lo,
  input  logic [DW-1:0] win_hi,
  input  logic [7:0]    cfg_byte,
  input  logic          stat_rd_done,
  output logic          irq_flag,
  output logic          irq_n
);

  localparam int KEY_W = 4;

  chan_sel_e        chan;
  logic [1:0]       persist;
  logic             done_en;
  logic [KEY_W-1:0] key_q;
  logic             cfg_change, conv_acc, hit, win_fire, set;

  assign chan       = chan_sel_e'(cfg_byte[1:0]);
  assign persist    = cfg_byte[3:2];
  assign done_en    = cfg_byte[4];
  assign conv_ready = 1'b1;
  assign conv_acc   = conv_valid && conv_ready;
  assign cfg_change = cfg_byte[KEY_W-1:0] != key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= cfg_byte[KEY_W-1:0];
  end

  lirq_window #(.DW(DW)) u_window (
    .chan      (chan),
    .red_res   (red_res),
    .green_res (green_res),
    .blue_res  (blue_res),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .hit       (hit)
  );

  lirq_persist u_persist (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_acc   (conv_acc),
    .hit        (hit),
    .persist    (persist),
    .cfg_change (cfg_change),
    .fire       (win_fire)
  );

  assign set = win_fire || (conv_acc && done_en);

  lirq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set),
    .clr   (stat_rd_done),
    .flag  (irq_flag),
    .pin_n (irq_n)
  );

  assert_fire_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(conv_valid && (cfg_byte[4] || cfg_byte[1:0] != 2'b00)));

  assert_rsvd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(cfg_byte[7:5]) != cfg_byte[7:5]) &&
    ($past(cfg_byte[3:0]) == cfg_byte[3:0]) |-> !cfg_change);

endmodule

// File: tb/test_light_irq_ctrl.sv
`timescale 1ns/1ps
module test_light_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic        conv_ready;
  logic [15:0] red_res = '0, green_res = '0, blue_res = '0;
  logic [15:0] win_lo = 16'd100, win_hi = 16'd200;
  logic [7:0]  cfg_byte = '0;
  logic        stat_rd_done = 1'b0;
  logic        irq_flag, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_run = 0;
  int m_key = 0;
  bit m_flag = 1'b0;

  always #10 clk = ~clk;

  light_irq_ctrl i_light_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .red_res(red_res), .green_res(green_res), .blue_res(blue_res),
    .win_lo(win_lo), .win_hi(win_hi), .cfg_byte(cfg_byte),
    .stat_rd_done(stat_rd_done), .irq_flag(irq_flag), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_key = 0; m_flag = 0;
    end else begin
      bit fire_any;
      int smp;
      bit outside;
      fire_any = 0;
      if (int'(cfg_byte[3:0]) != m_key) m_run = 0;
      m_key = int'(cfg_byte[3:0]);
      if (conv_valid) begin
        smp = (cfg_byte[1:0] == 2'd1) ? int'(green_res) :
              (cfg_byte[1:0] == 2'd2) ? int'(red_res) : int'(blue_res);
        outside = (cfg_byte[1:0] != 0) && (smp < int'(win_lo) || smp > int'(win_hi));
        if (outside) begin
          m_run = m_run + 1;
          if (m_run >= (1 << cfg_byte[3:2])) begin
            fire_any = 1;
            m_run = 0;
          end
        end else m_run = 0;
        if (cfg_byte[4]) fire_any = 1;
      end
      if (fire_any) m_flag = 1;
      else if (stat_rd_done) m_flag = 0;
    end
  end

  // comparison on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 model flag", int'(irq_flag), int'(m_flag));
      chk("R7 model pin", int'(irq_n), int'(!m_flag));
      chk("R12 ready", int'(conv_ready), 1);
    end
  end

  task automatic conv(input int r, input int g, input int b);
    @(negedge clk);
    conv_valid = 1'b1;
    red_res = 16'(r); green_res = 16'(g); blue_res = 16'(b);
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic conv_rd(input int g);
    @(negedge clk);
    conv_valid = 1'b1; stat_rd_done = 1'b1; green_res = 16'(g);
    @(negedge clk);
    conv_valid = 1'b0; stat_rd_done = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    stat_rd_done = 1'b1;
    @(negedge clk);
    stat_rd_done = 1'b0;
  endtask

  task automatic expect_flag(input string req, input int f);
    chk(req, int'(irq_flag), f);
    chk(req, int'(irq_n), 1 - f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flag", int'(irq_flag), 0);
    chk("R1 reset pin", int'(irq_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    expect_flag("R1 after release", 0);
    chk("R12 ready", int'(conv_ready), 1);

    // strict window on green, run length 1
    cfg_byte = 8'h01;
    conv(0, 150, 0);   expect_flag("R3 inside", 0);
    conv(0, 100, 0);   expect_flag("R3 equal low", 0);
    conv(0, 200, 0);   expect_flag("R3 equal high", 0);
    conv(0, 99, 0);    expect_flag("R3 below low", 1);
    conv(0, 150, 0);   expect_flag("R7 holds", 1);
    rd();              expect_flag("R7 cleared by read", 0);
    conv(0, 201, 0);   expect_flag("R3 above high", 1);
    rd();

    // channel selection
    cfg_byte = 8'h02;
    conv(150, 0, 999); expect_flag("R2 red ignores others", 0);
    conv(250, 150, 150); expect_flag("R2 red fires", 1);
    rd();
    cfg_byte = 8'h03;
    conv(0, 0, 150);   expect_flag("R2 blue ignores others", 0);
    conv(150, 150, 201); expect_flag("R2 blue fires", 1);
    rd();

    // run length 4
    cfg_byte = 8'h09;
    for (int i = 0; i < 3; i++) begin
      conv(0, 0, 0);   expect_flag("R4 run4 short", 0);
    end
    conv(0, 0, 0);     expect_flag("R4 run4 complete", 1);
    rd();
    conv(0, 0, 0); conv(0, 0, 0);
    conv(0, 150, 0);   expect_flag("R5 in-window", 0);
    for (int i = 0; i < 3; i++) begin
      conv(0, 0, 0);   expect_flag("R5 restarted", 0);
    end
    conv(0, 0, 0);     expect_flag("R5 run done", 1);
    rd();
    for (int i = 0; i < 3; i++) begin
      conv(0, 0, 0);   expect_flag("R5 restart after fire", 0);
    end
    conv(0, 0, 0);     expect_flag("R5 second fire", 1);
    rd();

    // run length 8
    cfg_byte = 8'h0D;
    for (int i = 0; i < 7; i++) begin
      conv(0, 999, 0); expect_flag("R4 run8 short", 0);
    end
    conv(0, 999, 0);   expect_flag("R4 run8 complete", 1);
    rd();

    // configuration change restarts the run
    cfg_byte = 8'h05;
    conv(0, 0, 0);     expect_flag("R6 first of two", 0);
    cfg_byte = 8'h06;
    conv(0, 0, 0);     expect_flag("R6 restart on change", 0);
    conv(0, 0, 0);     expect_flag("R6 run after change", 1);
    rd();

    // reserved bits
    cfg_byte = 8'h05;
    conv(0, 0, 0);     expect_flag("R11 first", 0);
    cfg_byte = 8'hE5;
    conv(0, 0, 0);     expect_flag("R11 reserved change keeps run", 1);
    rd();

    // set wins over read
    cfg_byte = 8'h01;
    rd();              expect_flag("R7 read while clear", 0);
    conv(0, 0, 0);     expect_flag("R8 fire", 1);
    conv_rd(0);        expect_flag("R8 set beats read", 1);
    rd();              expect_flag("R8 later read clears", 0);

    // conversion-done path
    cfg_byte = 8'h11;
    conv(0, 150, 0);   expect_flag("R9 done enable fires", 1);
    rd();
    cfg_byte = 8'h10;
    conv(0, 150, 0);   expect_flag("R10 done path with no channel", 1);
    rd();
    cfg_byte = 8'h00;
    conv(0, 0, 0);     expect_flag("R10 no channel low", 0);
    conv(65535, 65535, 65535); expect_flag("R10 no channel high", 0);
    cfg_byte = 8'h01;
    conv(0, 150, 0);   expect_flag("R9 disabled no fire", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule